// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers eight interrupt sources into one status register and one mask register, and drives a single active-low interrupt line to a host processor. Six sources arrive as one-cycle event pulses. The other two come from an internal monitor that watches a processor access window for synchronous transfer data. That monitor flags the window opening. It flags an overflow when the window closes and no enabled channel's data register was touched while it was open.

The host reaches the block through a small register port. A one-bit address selects between the status view (0) and the mask (1). Reads are combinational. A read of the status view clears the bits it returned, on the clock edge that ends the read cycle. Masked events are not dropped: they wait internally and appear once their mask bit is cleared. One source is the exception: it is always visible in status but can never drive the interrupt line while it is masked. A mask write made while the line is active pulls the line inactive for a fixed number of cycles, so that an edge-sensitive host sees a fresh edge.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the mask reads 0x00, the status view reads 0x00 and `irq_n` is 1.
- R2: Status and mask bit positions are fixed. `src_evt[5:0]` set status bits 7..2 in that order, and bit 6 is the always-visible source. Bit 1 is the window-open flag and bit 0 is the window-overflow flag.
- R3: An event whose mask bit is 1 stays latched but is not shown in the status view. It appears there in the cycle after its mask bit is written to 0.
- R4: Bit 6 is shown in the status view whatever its mask bit is. While its mask bit is 1, it never pulls `irq_n` low.
- R5: Outside a forced-inactive period, `irq_n` is 0 exactly when some pending status bit, other than a masked bit 6, has its mask bit at 0.
- R6: A mask write in a cycle where `irq_n` is 0 holds `irq_n` at 1 for exactly 2 cycles after that edge. After that, `irq_n` follows R5 with the new mask.
- R7: `win_open` sets status bit 1 only when at least one bit of `ch_en` is 1. With `ch_en` = 0 it has no effect.
- R8: `win_close` during an open window sets status bit 0 unless channel A (enabled by `ch_en[0]`) or channel B (enabled by `ch_en[1]`) saw an access strobe while the window was open, counting the close cycle. Strobes on a disabled channel do not count.
- R9: A status read clears only the bits it returned. A masked hidden event and an event arriving in the same cycle as the read both stay pending.
- R10: The mask reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 1 | 0 = status view, 1 = mask |
| reg_wr | input | 1 | Write strobe (mask only) |
| reg_rd | input | 1 | Read strobe; clears returned status bits |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| src_evt | input | 6 | Event pulses for status bits 7..2 |
| win_open | input | 1 | Access window opens |
| win_close | input | 1 | Access window closes |
| ch_en | input | 2 | Transfer channel enables, bit 0 = A, bit 1 = B |
| dat_acc_a | input | 1 | Channel A data register access strobe |
| dat_acc_b | input | 1 | Channel B data register access strobe |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The bench builds the block with its defaults: eight status bits and a forced-inactive period of two cycles. Eight bits is enough to place every special bit next to ordinary ones in one byte. Two cycles makes it cheap to hit a mask write during a forced-inactive period, which restarts that period. Random stimulus makes window open, close and access strobes collide in the same cycle, so the same-cycle edge cases of the overflow rule are exercised.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants for the interrupt status and mask controller.
// Assumes eight status bits; the positions below are decoded by the host.
package irq_ctrl_pkg;
    localparam int STAT_W    = 8;
    localparam int EXT_W     = STAT_W - 2;
    localparam int IDX_SHOWN = 6;   // always-visible source
    localparam int IDX_WOPEN = 1;   // window-open flag
    localparam int IDX_WOVF  = 0;   // window-overflow flag
    localparam int NUM_CH    = 2;
endpackage

// File: rtl/irq_stat_bank.sv
// Pending-event latches and mask register.
// Builds the host-visible status view and the interrupt request.
// Assumes read and clear happen on the edge that ends the read cycle.
module irq_stat_bank #(
    parameter int W         = 8,
    parameter int SHOWN_IDX = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    input  logic         rd_clr,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] view,
    output logic         req
);
    localparam logic [W-1:0] SHOWN_BIT = W'(1) << SHOWN_IDX;

    logic [W-1:0] clr_bits;

    // Visible bits: unmasked pending bits plus the always-shown source.
    always_comb view = (pend_q & ~mask_q) | (pend_q & SHOWN_BIT);

    // Request: any unmasked pending bit; a masked shown source never counts.
    always_comb req = |(pend_q & ~mask_q);

    // Bits cleared by a status read are exactly those returned.
    always_comb clr_bits = rd_clr ? view : '0;

    // Latch events; new events win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | evt;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end
endmodule

// File: rtl/stx_win_mon.sv
// Access-window monitor for synchronous transfer channels.
// Flags the window opening (when any channel is enabled) and flags an overflow
// when the window closes unserviced. Assumes open/close are one-cycle strobes.
module stx_win_mon #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_open,
    input  logic           win_close,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] acc,
    output logic           open_evt,
    output logic           ovf_evt
);
    logic in_win_q;
    logic served_q;
    logic acc_hit;

    // An access counts only on an enabled channel.
    always_comb acc_hit = |(acc & ch_en);

    // Window-open event needs at least one enabled channel.
    always_comb open_evt = win_open && (|ch_en);

    // Overflow when an open window closes with no service (close cycle included).
    always_comb ovf_evt = win_close && in_win_q && !served_q && !acc_hit;

    // Track window state and service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_win_q <= 1'b0;
            served_q <= 1'b0;
        end else if (open_evt) begin
            in_win_q <= 1'b1;
            served_q <= 1'b0;
        end else if (win_close) begin
            in_win_q <= 1'b0;
            served_q <= 1'b0;
        end else if (in_win_q && acc_hit) begin
            served_q <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_out_gate.sv
// Drives the active-low interrupt line.
// A mask write while the request is active forces the line inactive for
// BLANK_CYC cycles. Assumes BLANK_CYC >= 1.
module irq_out_gate #(
    parameter int BLANK_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_we,
    input  logic req,
    output logic irq_n
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

    logic [CW-1:0] blank_q;

    // Load on a mask write over an active request, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 blank_q <= '0;
        else if (mask_we && req)    blank_q <= LOAD;
        else if (blank_q != '0)     blank_q <= blank_q - 1'b1;
    end

    // Line low only when requested and not blanked.
    always_comb irq_n = !(req && (blank_q == '0));
endmodule

// File: rtl/irq_ctrl_top.sv
// Interrupt status and mask controller top.
// Combines external events with the window monitor flags and serves a
// two-register host port (0 = status view, clear on read; 1 = mask).
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int BLANK_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [EXT_W-1:0]  src_evt,
    input  logic              win_open,
    input  logic              win_close,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              dat_acc_a,
    input  logic              dat_acc_b,
    output logic              irq_n
);
    logic [STAT_W-1:0] evt_all;
    logic [STAT_W-1:0] pend_q;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] view;
    logic              req;
    logic              open_evt;
    logic              ovf_evt;
    logic              mask_we;
    logic              stat_rd;

    // Decode host strobes.
    always_comb mask_we = reg_wr && reg_addr;
    always_comb stat_rd = reg_rd && !reg_addr;

    // Assemble event vector: external sources above the window flags.
    always_comb begin
        evt_all            = '0;
        evt_all[STAT_W-1:2] = src_evt;
        evt_all[IDX_WOPEN] = open_evt;
        evt_all[IDX_WOVF]  = ovf_evt;
    end

    // Read mux.
    always_comb reg_rdata = reg_addr ? mask_q : view;

    stx_win_mon #(.NCH(NUM_CH)) win_i (
        .clk(clk), .rst_n(rst_n),
        .win_open(win_open), .win_close(win_close),
        .ch_en(ch_en), .acc({dat_acc_b, dat_acc_a}),
        .open_evt(open_evt), .ovf_evt(ovf_evt)
    );

    irq_stat_bank #(.W(STAT_W), .SHOWN_IDX(IDX_SHOWN)) bank_i (
        .clk(clk), .rst_n(rst_n), .evt(evt_all),
        .mask_we(mask_we), .mask_wd(reg_wdata), .rd_clr(stat_rd),
        .pend_q(pend_q), .mask_q(mask_q), .view(view), .req(req)
    );

    irq_out_gate #(.BLANK_CYC(BLANK_CYC)) gate_i (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .req(req), .irq_n(irq_n)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
// Protocol checker bound to irq_ctrl_top; observes ports and bank state.
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] reg_rdata,
    input logic              win_open,
    input logic              win_close,
    input logic [NUM_CH-1:0] ch_en,
    input logic [STAT_W-1:0] pend_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq_n
);
    AST_MASKED_SHOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q) == '0) |-> irq_n);  // R4
    AST_BLANK_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && !irq_n) |=> irq_n ##1 irq_n);  // R6
    AST_OPEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[IDX_WOPEN]) |-> $past(win_open && (ch_en != '0)));  // R7
    AST_OVF_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[IDX_WOVF]) |-> $past(win_close));  // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_addr && reg_rdata[IDX_WOVF] && !win_close) |=> !pend_q[IDX_WOVF]);  // R9
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> (mask_q == $past(reg_wdata)));  // R10
endmodule

bind irq_ctrl_top irq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_open(win_open), .win_close(win_close), .ch_en(ch_en),
    .pend_q(pend_q), .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/irq_ctrl_top_tb_top.sv
// Self-checking bench: reference model from the requirements, random plus directed.
module irq_ctrl_top_tb_top;
    localparam logic [7:0] SHOWN = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] src_evt = '0;
    logic win_open = 1'b0, win_close = 1'b0, dat_acc_a = 1'b0, dat_acc_b = 1'b0;
    logic [1:0] ch_en = '0;
    logic irq_n;

    int n_run = 0, n_fail = 0;
    logic [7:0] m_pend, m_mask;
    int m_blank;
    logic m_inwin, m_served;
    logic [7:0] s_rdata;
    logic s_irq;

    always #5 clk = ~clk;

    irq_ctrl_top dut_i (.*);

    function automatic logic [7:0] f_view(logic [7:0] p, logic [7:0] m);
        return (p & ~m) | (p & SHOWN);
    endfunction
    function automatic logic f_req(logic [7:0] p, logic [7:0] m);
        return |(p & ~m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = '0; m_mask = '0; m_blank = 0; m_inwin = 0; m_served = 0;
    endtask

    // One cycle: drive at negedge, compare, advance model at posedge.
    task automatic cyc(logic [5:0] ev, logic wr, logic rd, logic ad, logic [7:0] wd,
                       logic wo, logic wc, logic [1:0] en, logic aa, logic ab);
        logic sin, hit, sov;
        logic [7:0] clr;
        @(negedge clk);
        src_evt = ev; reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
        win_open = wo; win_close = wc; ch_en = en; dat_acc_a = aa; dat_acc_b = ab;
        #1;
        s_rdata = reg_rdata; s_irq = irq_n;
        check(ad ? "R10 mask readback" : "R9 status view", reg_rdata,
              ad ? m_mask : f_view(m_pend, m_mask));
        check(m_blank != 0 ? "R6 forced inactive" : "R5 irq level", irq_n,
              (m_blank == 0) ? !f_req(m_pend, m_mask) : 1'b1);
        @(posedge clk);
        sin = wo && (en != 0);
        hit = (aa && en[0]) || (ab && en[1]);
        sov = wc && m_inwin && !m_served && !hit;
        clr = (rd && !ad) ? f_view(m_pend, m_mask) : 8'h00;
        if (wr && ad && f_req(m_pend, m_mask)) m_blank = 2;
        else if (m_blank != 0) m_blank--;
        m_pend = (m_pend & ~clr) | {ev, sin, sov};
        if (wr && ad) m_mask = wd;
        if (sin) begin m_inwin = 1; m_served = 0; end
        else if (wc) begin m_inwin = 0; m_served = 0; end
        else if (m_inwin && hit) m_served = 1;
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0,0,0); endtask
    task automatic rd_stat(); cyc(0,0,1,0,0,0,0,0,0,0); endtask
    task automatic wr_mask(logic [7:0] v); cyc(0,1,0,1,v,0,0,0,0,0); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        cyc(0,0,0,0,0,0,0,0,0,0); check("R1 status", s_rdata, 8'h00); check("R1 irq", s_irq, 1'b1);
        cyc(0,0,0,1,0,0,0,0,0,0); check("R1 mask", s_rdata, 8'h00);

        // R2 bit positions
        cyc(6'b100000,0,0,0,0,0,0,0,0,0); rd_stat(); check("R2 top bit", s_rdata, 8'h80);
        cyc(6'b000001,0,0,0,0,0,0,0,0,0); rd_stat(); check("R2 bit2", s_rdata, 8'h04);

        // R3 masked latch then unmask
        wr_mask(8'h80); cyc(6'b100000,0,0,0,0,0,0,0,0,0);
        idle(); check("R3 hidden irq", s_irq, 1'b1);
        rd_stat(); check("R3 hidden", s_rdata, 8'h00);
        wr_mask(8'h00); rd_stat(); check("R3 revealed", s_rdata, 8'h80);

        // R4 always-shown source while masked
        wr_mask(8'h40); cyc(6'b010000,0,0,0,0,0,0,0,0,0);
        idle(); check("R4 no irq", s_irq, 1'b1);
        rd_stat(); check("R4 shown", s_rdata, 8'h40);

        // R6 forced inactive after mask write
        wr_mask(8'h00); cyc(6'b100000,0,0,0,0,0,0,0,0,0);
        idle(); check("R5 irq active", s_irq, 1'b0);
        wr_mask(8'h01);
        idle(); check("R6 blank c1", s_irq, 1'b1);
        idle(); check("R6 blank c2", s_irq, 1'b1);
        idle(); check("R6 reasserted", s_irq, 1'b0);
        rd_stat(); wr_mask(8'h00);

        // R7 window open needs an enabled channel
        cyc(0,0,0,0,0,1,0,2'b00,0,0); rd_stat(); check("R7 disabled", s_rdata, 8'h00);
        cyc(0,0,0,0,0,1,0,2'b10,0,0); rd_stat(); check("R7 enabled", s_rdata, 8'h02);

        // R8 overflow rules
        cyc(0,0,0,0,0,0,1,2'b01,0,0); rd_stat(); check("R8 unserviced", s_rdata, 8'h01);
        cyc(0,0,0,0,0,1,0,2'b01,0,0); cyc(0,0,0,0,0,0,0,2'b01,0,1);
        cyc(0,0,0,0,0,0,1,2'b01,0,0); rd_stat(); check("R8 disabled ch access", s_rdata, 8'h03);
        cyc(0,0,0,0,0,1,0,2'b01,0,0); cyc(0,0,0,0,0,0,1,2'b01,1,0);
        rd_stat(); check("R8 serviced at close", s_rdata, 8'h02);

        // R9 same-cycle event survives read; hidden event survives read
        wr_mask(8'h20); cyc(6'b001000,0,0,0,0,0,0,0,0,0);
        cyc(6'b100000,0,1,0,0,0,0,0,0,0); check("R9 read value", s_rdata, 8'h00);
        rd_stat(); check("R9 late event kept", s_rdata, 8'h80);
        wr_mask(8'h00); rd_stat(); check("R9 hidden kept", s_rdata, 8'h20);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            cyc(6'($urandom & $urandom & $urandom),
                op == 0, op inside {[1:2]}, op[0] ^ op[2], 8'($urandom & $urandom),
                ($urandom % 8) == 0, ($urandom % 6) == 0, 2'($urandom),
                ($urandom % 5) == 0, ($urandom % 5) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule